// File: doc/BRIEF.md
# Double-pumped four-read two-write register file

This block holds the 32 architectural registers, each 32 bits wide, of a two-wide in-order core. In every core cycle it serves four independent register reads and accepts up to two register writes. It does this without a true six-port array. It keeps two replicated copies of the register state, and each copy has only two read ports and one write port. The copies run on a fast clock at twice the core rate, so each core cycle spans two fast edges.

The fast clock is the block's only clock. A phase input tells the block which of the two fast edges of a core cycle is arriving. On the phase-0 edge, both copies are read and the first write port is committed. On the phase-1 edge, the second write port is committed. Both write ports go to both copies, so the copies never diverge.

Read results are registered on the phase-0 edge. They stay steady until the next phase-0 edge. They always show the register state as it stood when the core cycle began.

Top module: `regfile_dp4r2w`

## Requirements
- R1: While `rst_ni` is low, all 32 registers and all four read outputs are cleared to zero.
- R2: Read port n returns the register chosen by its own address. The value appears after the fast edge where `phase_i` is 0 and holds unchanged across the following phase-1 edge.
- R3: Copy 0 serves read ports 0 and 1, and copy 1 serves read ports 2 and 3. Any two ports given the same address in a cycle return the same value.
- R4: Write port 0 is applied to both copies on the phase-0 edge, and write port 1 on the phase-1 edge. Each applies only when its enable bit is 1.
- R5: When both write ports are enabled for the same register in one core cycle, write port 1's data is what remains.
- R6: A write does not show on any read port in the core cycle that issues it. It shows from the next core cycle on.
- R7: Address 0 always reads as zero. An enabled write to address 0 leaves every register unchanged.
- R8: `phase_i` must alternate 0, 1, 0, 1 on successive fast edges out of reset.
- R9: A write port whose enable is 0 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x_i | input | 1 | Fast clock, twice the core rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| phase_i | input | 1 | 0 on the first fast edge of a core cycle, 1 on the second |
| wr_en_i | input | 2 | Write enable, one bit per write port |
| wr_addr_i | input | 2x5 | Target register of each write port |
| wr_data_i | input | 2x32 | Data of each write port |
| rd_addr_i | input | 4x5 | Register address of each read port |
| rd_data_o | output | 4x32 | Registered read data of each read port |

## Verification
The embedded properties watch these behaviours on every fast edge:
- read data stays put across the phase-1 edge;
- address 0 reads as zero;
- two ports that share an address, one on each copy, agree;
- the phase input alternates.

Some behaviours depend on the data history, so only the bench's reference array can show them. These are write ordering and the collision winner, the one-cycle delay before a write becomes visible, blocked writes to register 0, and disabled write ports.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int unsigned NREG   = 32;
    localparam int unsigned XLEN   = 32;
    localparam int unsigned AW     = $clog2(NREG);
    localparam int unsigned NUM_RD = 4;
    localparam int unsigned NUM_WR = 2;
    localparam int unsigned NBANK  = 2;
    localparam int unsigned RD_PER_BANK = NUM_RD / NBANK;

    typedef struct packed {
        logic            en;
        logic [AW-1:0]   addr;
        logic [XLEN-1:0] data;
    } wr_cmd_t;
endpackage

// File: rtl/rf_wsel.sv
module rf_wsel
    import rf_pkg::*;
(
    input  logic                         phase_i,
    input  logic [NUM_WR-1:0]            wr_en_i,
    input  logic [NUM_WR-1:0][AW-1:0]    wr_addr_i,
    input  logic [NUM_WR-1:0][XLEN-1:0]  wr_data_i,
    output wr_cmd_t                      wr_cmd_o
);
    localparam int unsigned SW = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;

    logic [SW-1:0] sel;

    // Phase picks the write port: port 0 first, port 1 second (R4, R5)
    always_comb begin
        sel           = SW'(phase_i);
        wr_cmd_o.addr = wr_addr_i[sel];
        wr_cmd_o.data = wr_data_i[sel];
        // Register 0 is read-only: drop its writes here (R7, R9)
        wr_cmd_o.en   = wr_en_i[sel] && (wr_addr_i[sel] != '0);
    end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
    import rf_pkg::*;
#(
    parameter int unsigned NRD = RD_PER_BANK
) (
    input  logic                      clk2x_i,
    input  logic                      rst_ni,
    input  logic                      phase_i,
    input  wr_cmd_t                   wr_cmd_i,
    input  logic [NRD-1:0][AW-1:0]    rd_addr_i,
    output logic [NRD-1:0][XLEN-1:0]  rd_data_o
);
    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] mem;
        logic [NRD-1:0][XLEN-1:0]  rdat;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!phase_i) begin
            // Read the state that stood when the core cycle began (R2, R6)
            for (int rp = 0; rp < NRD; rp++) begin
                st_d.rdat[rp] = (rd_addr_i[rp] == '0) ? '0 : st_q.mem[rd_addr_i[rp]];
            end
        end
        if (wr_cmd_i.en) begin
            st_d.mem[wr_cmd_i.addr] = wr_cmd_i.data;
        end
    end

    always_ff @(posedge clk2x_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.rdat;

    for (genvar rp = 0; rp < NRD; rp++) begin : g_chk
        AST_ZERO_READ: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
            (!phase_i && rd_addr_i[rp] == '0) |=> (rd_data_o[rp] == '0)); // R7
    end

    AST_READ_HOLD: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
        phase_i |=> $stable(rd_data_o)); // R2
endmodule

// File: rtl/regfile_dp4r2w.sv
module regfile_dp4r2w
    import rf_pkg::*;
(
    input  logic                           clk2x_i,
    input  logic                           rst_ni,
    input  logic                           phase_i,
    input  logic [NUM_WR-1:0]              wr_en_i,
    input  logic [NUM_WR-1:0][AW-1:0]      wr_addr_i,
    input  logic [NUM_WR-1:0][XLEN-1:0]    wr_data_i,
    input  logic [NUM_RD-1:0][AW-1:0]      rd_addr_i,
    output logic [NUM_RD-1:0][XLEN-1:0]    rd_data_o
);
    wr_cmd_t wr_cmd;

    rf_wsel u_wsel (
        .phase_i   (phase_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .wr_cmd_o  (wr_cmd)
    );

    // Every copy sees the same write stream, so all copies stay equal (R3, R4)
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        rf_bank #(.NRD(RD_PER_BANK)) u_bank (
            .clk2x_i   (clk2x_i),
            .rst_ni    (rst_ni),
            .phase_i   (phase_i),
            .wr_cmd_i  (wr_cmd),
            .rd_addr_i (rd_addr_i[b*RD_PER_BANK +: RD_PER_BANK]),
            .rd_data_o (rd_data_o[b*RD_PER_BANK +: RD_PER_BANK])
        );
    end

    AST_COPY_MATCH: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
        (!phase_i && rd_addr_i[0] == rd_addr_i[RD_PER_BANK])
        |=> (rd_data_o[0] == rd_data_o[RD_PER_BANK])); // R3

    AST_PHASE_RISE: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
        !phase_i |=> phase_i); // R8

    AST_PHASE_FALL: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
        phase_i |=> !phase_i); // R8
endmodule

// File: tb/regfile_dp4r2w_tb_top.sv
module regfile_dp4r2w_tb_top;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             phase = 1'b0;
    logic [1:0]       wr_en = '0;
    logic [1:0][4:0]  wr_addr = '0;
    logic [1:0][31:0] wr_data = '0;
    logic [3:0][4:0]  rd_addr = '0;
    logic [3:0][31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] model [32];

    always #2.5 clk = ~clk;

    regfile_dp4r2w dut_i (
        .clk2x_i(clk), .rst_ni(rst_n), .phase_i(phase),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    task automatic check(input string tag, input int port, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s port %0d actual %h expected %h", tag, port, act, exp);
        end
    endtask

    // Called at a falling edge; returns at a falling edge one core cycle later
    task automatic core_cycle(input logic [1:0] we, input logic [1:0][4:0] wa,
                              input logic [1:0][31:0] wd, input logic [3:0][4:0] ra,
                              input string tag);
        logic [31:0] exp [4];
        for (int i = 0; i < 4; i++) exp[i] = model[ra[i]];
        phase = 1'b0; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        @(negedge clk);
        phase = 1'b1;
        for (int i = 0; i < 4; i++) check({tag, " mid"}, i, rd_data[i], exp[i]);
        @(negedge clk);
        for (int i = 0; i < 4; i++) check(tag, i, rd_data[i], exp[i]);
        if (rst_n) begin
            for (int w = 0; w < 2; w++)
                if (we[w] && wa[w] != 5'd0) model[wa[w]] = wd[w];
        end
    endtask

    task automatic read4(input logic [3:0][4:0] ra, input string tag);
        core_cycle(2'b00, '0, '0, ra, tag);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        @(negedge clk);
        // R1: reset holds everything at zero, including write attempts
        core_cycle(2'b11, {5'd3, 5'd4}, {32'hdead0001, 32'hdead0002}, {5'd1, 5'd2, 5'd3, 5'd4}, "R1");
        read4({5'd1, 5'd2, 5'd3, 5'd4}, "R1");
        rst_n = 1'b1;
        for (int a = 0; a < 32; a += 4)
            read4({5'(a+3), 5'(a+2), 5'(a+1), 5'(a)}, "R1");

        // R4: both ports write distinct registers, then every port reads them
        core_cycle(2'b11, {5'd9, 5'd8}, {32'h9999_0009, 32'h8888_0008}, {5'd8, 5'd9, 5'd8, 5'd9}, "R6");
        read4({5'd9, 5'd8, 5'd9, 5'd8}, "R4");
        // R5: collision on register 12, port 1 wins
        core_cycle(2'b11, {5'd12, 5'd12}, {32'h2222_2222, 32'h1111_1111}, {5'd12, 5'd0, 5'd12, 5'd0}, "R5");
        read4({5'd12, 5'd12, 5'd12, 5'd12}, "R5");
        // R7: writes to register 0 are dropped
        core_cycle(2'b11, {5'd0, 5'd0}, {32'hffff_ffff, 32'heeee_eeee}, {5'd0, 5'd0, 5'd0, 5'd0}, "R7");
        read4({5'd0, 5'd9, 5'd0, 5'd8}, "R7");
        // R9: disabled ports leave registers alone
        core_cycle(2'b00, {5'd8, 5'd9}, {32'h0bad_0bad, 32'h0bad_0bad}, {5'd8, 5'd9, 5'd12, 5'd0}, "R9");
        read4({5'd8, 5'd9, 5'd8, 5'd9}, "R9");
        core_cycle(2'b10, {5'd20, 5'd21}, {32'h0000_0020, 32'h0000_0021}, {5'd20, 5'd21, 5'd20, 5'd21}, "R6");
        read4({5'd20, 5'd21, 5'd21, 5'd20}, "R9");
        // R6: write then read same register across cycles
        core_cycle(2'b01, {5'd0, 5'd5}, {32'h0, 32'h5555_aaaa}, {5'd5, 5'd5, 5'd5, 5'd5}, "R6");
        read4({5'd5, 5'd5, 5'd5, 5'd5}, "R6");

        // R2/R3: random dual writes and quadruple reads against the model
        for (int n = 0; n < 600; n++) begin
            logic [1:0]       we;
            logic [1:0][4:0]  wa;
            logic [1:0][31:0] wd;
            logic [3:0][4:0]  ra;
            we = 2'($urandom);
            for (int w = 0; w < 2; w++) begin
                wa[w] = 5'($urandom);
                wd[w] = $urandom;
            end
            for (int r = 0; r < 4; r++) ra[r] = 5'($urandom);
            if (n % 7 == 0) ra[2] = ra[0];
            if (n % 11 == 0) wa[1] = wa[0];
            core_cycle(we, wa, wd, ra, (n % 2 == 0) ? "R2" : "R3");
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule